// File: doc/BRIEF.md
# Load-Store Access Unit

This unit carries out the data-movement operations of a small processor against a byte-addressed, synchronous data memory. One request is accepted at a time. It carries an operation code, an access-size code, a register value and an address value. The unit then drives the memory port (address, byte enables, lane-aligned write data, write strobe) and, for reads, turns the returned bus word into a register-sized result. The upper part of that result is either copies of the item's top bit or zeros. Push and pop always move one full register and also return the stepped stack address. A copy returns the register value without touching memory.

Control is a four-state machine. IDLE waits for `req_valid`. An accepted memory operation moves IDLE -> ACCESS. An illegal request or a copy moves IDLE -> FINISH. In ACCESS the memory enable is high for one cycle. A store or push then goes ACCESS -> FINISH. A load or pop goes ACCESS -> CAPTURE, where the returned word is extended and registered, and then CAPTURE -> FINISH. FINISH raises `done` for one cycle and always returns to IDLE. The processor data width `DW` may be 16, 32 or 64 bits.

Top module: `lsu_core`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_en` and `mem_we` are low, and `result` and `addr_next` are zero.
- R2: Size codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Operation codes are 0 = signed load, 1 = unsigned load, 2 = store, 3 = push, 4 = pop and 5 = copy. An opcode above 5, or a size code above DW on a load or store, completes with `done` and `err` high in the cycle after acceptance. Such a request never raises `mem_en` and leaves memory unchanged.
- R3: A signed load returns the item read from the request address, with its top bit copied into every higher result bit.
- R4: An unsigned load returns the item read from the request address, with zeros in every higher result bit.
- R5: The byte at address a uses bus lane l = a mod (DW/8), which is data bits [8l+7:8l] (little-endian). `mem_addr` equals the request address. `mem_be` has exactly the item's bytes set. Accesses are naturally aligned.
- R6: A store writes the low bytes of `req_data` to the item's bytes starting at the request address and leaves the other bytes of the word unchanged.
- R7: A push writes the whole of `req_data` at the request address, whatever the size code. `addr_next` becomes the address plus DW/8.
- R8: A pop reads a whole register from the request address into `result`. `addr_next` becomes the address minus DW/8 (modulo 2^AW).
- R9: A copy sets `result` to `req_data` and `addr_next` to the request address. It raises no `mem_en` and completes in the cycle after acceptance.
- R10: Let a request be accepted at clock edge E. Then `mem_en` is high from E to E+1. Loads and pops raise `done` from E+2 to E+3. Stores and pushes raise it from E+1 to E+2. `done` lasts exactly one cycle.
- R11: While `busy` is high, `req_valid` is ignored. A request presented then starts no operation and changes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_op | input | 3 | Operation code |
| req_size | input | 2 | Access size code |
| req_data | input | DW | Register value to store, push or copy |
| req_addr | input | AW | Byte address from the address register |
| mem_addr | output | AW | Memory byte address |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | DW/8 | Byte-lane enables |
| mem_wdata | output | DW | Lane-aligned write data |
| mem_rdata | input | DW | Read word, valid the cycle after `mem_en` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal request, high with `done` |
| result | output | DW | Load, pop or copy result |
| addr_next | output | AW | Updated address register value |

## Verification
Loads are checked first against memory bytes whose top bit is set and then against bytes whose top bit is clear. Signed and unsigned reads of the same item therefore differ only in the fill bits, which separates the two extension paths. Stores and loads of each size are placed at every legal lane offset, and the whole surrounding word is compared afterwards. This catches wrong byte enables and wrong lane shifts that a read of the same address alone would hide. Push and pop are tried with every size code and with an address at zero, which shows that the size code is ignored and that the address wraps on the step down. Illegal sizes, an unused opcode and requests made while busy confirm that nothing reaches memory or the result in those cases.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_SX = 3'd0,
        OP_LOAD_ZX = 3'd1,
        OP_STORE   = 3'd2,
        OP_PUSH    = 3'd3,
        OP_POP     = 3'd4,
        OP_COPY    = 3'd5
    } lsu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_FINISH  = 2'd3
    } lsu_state_e;

endpackage

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
    parameter int DW     = 32,
    parameter int LANE_W = 2
) (
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size_code,
    input  logic [DW-1:0]     data_in,
    output logic [DW/8-1:0]   byte_en,
    output logic [DW-1:0]     data_out
);
    localparam int NB = DW / 8;

    int first_byte;
    int byte_count;

    always_comb begin
        first_byte = int'(lane);
        byte_count = 1 << size_code;
        if (byte_count > NB) byte_count = NB;
        data_out = data_in << (first_byte * 8);
    end

    for (genvar b = 0; b < NB; b++) begin : g_be
        assign byte_en[b] = (b >= first_byte) && (b < first_byte + byte_count);
    end

endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend #(
    parameter int DW     = 32,
    parameter int LANE_W = 2
) (
    input  logic [DW-1:0]     bus_word,
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size_code,
    input  logic              sign_fill,
    output logic [DW-1:0]     value
);
    logic [DW-1:0] shifted;
    logic          top_bit;
    int            item_bits;

    always_comb begin
        shifted   = bus_word >> (int'(lane) * 8);
        item_bits = 8 << size_code;
        if (item_bits > DW) item_bits = DW;
        top_bit   = shifted[item_bits-1];
        for (int i = 0; i < DW; i++) begin
            value[i] = (i < item_bits) ? shifted[i] : (sign_fill & top_bit);
        end
    end

endmodule

// File: rtl/lsu_core.sv
module lsu_core
    import lsu_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [1:0]      req_size,
    input  logic [DW-1:0]   req_data,
    input  logic [AW-1:0]   req_addr,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_en,
    output logic            mem_we,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [DW-1:0]   result,
    output logic [AW-1:0]   addr_next
);
    localparam int            NB        = DW / 8;
    localparam int            LANE_W    = $clog2(NB);
    localparam logic [1:0]    FULL_SIZE = 2'($clog2(NB));
    localparam logic [AW-1:0] STEP      = AW'(NB);

    lsu_state_e    state_q, state_d;
    lsu_op_e       op_q;
    logic [1:0]    size_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] addr_q;
    logic          err_q;
    logic [DW-1:0] result_q;
    logic [AW-1:0] next_q;

    logic          accept;
    logic          bad_req;
    logic          is_copy;
    logic          whole_reg;
    logic [1:0]    eff_size;
    logic          writes;
    logic          reads;
    logic [DW/8-1:0] lane_be;
    logic [DW-1:0] lane_wdata;
    logic [DW-1:0] load_value;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign whole_reg = (req_op == OP_PUSH) || (req_op == OP_POP);
    assign is_copy   = (req_op == OP_COPY);
    assign bad_req   = (req_op > OP_COPY) ||
                       (!whole_reg && !is_copy && (int'(req_size) > int'(FULL_SIZE)));
    assign eff_size  = whole_reg ? FULL_SIZE : req_size;
    assign writes    = (op_q == OP_STORE) || (op_q == OP_PUSH);
    assign reads     = (op_q == OP_LOAD_SX) || (op_q == OP_LOAD_ZX) || (op_q == OP_POP);

    lsu_lane_align #(.DW(DW), .LANE_W(LANE_W)) i_align (
        .lane      (addr_q[LANE_W-1:0]),
        .size_code (size_q),
        .data_in   (data_q),
        .byte_en   (lane_be),
        .data_out  (lane_wdata)
    );

    lsu_load_extend #(.DW(DW), .LANE_W(LANE_W)) i_extend (
        .bus_word  (mem_rdata),
        .lane      (addr_q[LANE_W-1:0]),
        .size_code (size_q),
        .sign_fill (op_q == OP_LOAD_SX),
        .value     (load_value)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (bad_req || is_copy) ? ST_FINISH : ST_ACCESS;
            end
            ST_ACCESS:  state_d = reads ? ST_CAPTURE : ST_FINISH;
            ST_CAPTURE: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_LOAD_SX;
            size_q   <= '0;
            data_q   <= '0;
            addr_q   <= '0;
            err_q    <= 1'b0;
            result_q <= '0;
            next_q   <= '0;
        end else begin
            if (accept) begin
                op_q   <= lsu_op_e'(req_op);
                size_q <= eff_size;
                data_q <= req_data;
                addr_q <= req_addr;
                err_q  <= bad_req;
                if (is_copy) result_q <= req_data;
                if (!bad_req && req_op == OP_PUSH)     next_q <= req_addr + STEP;
                else if (!bad_req && req_op == OP_POP) next_q <= req_addr - STEP;
                else                                   next_q <= req_addr;
            end
            if (state_q == ST_CAPTURE) result_q <= load_value;
        end
    end

    // outputs decoded from state
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACCESS: begin
                busy   = 1'b1;
                mem_en = 1'b1;
                mem_we = writes;
                mem_be = lane_be;
            end
            ST_CAPTURE: busy = 1'b1;
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
                err  = err_q;
            end
        endcase
        mem_addr  = addr_q;
        mem_wdata = lane_wdata;
        result    = result_q;
        addr_next = next_q;
    end

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_en,
    input logic            mem_we,
    input logic [DW/8-1:0] mem_be,
    input logic            done,
    input logic            err,
    input logic            busy
);
    assert_we_with_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    assert_be_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_be != '0));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_write_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> done);

    assert_read_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (!done ##1 done));

    assert_err_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_err_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(mem_en));

    assert_en_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);
endmodule

bind lsu_core lsu_checker #(.DW(DW)) i_lsu_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_en (mem_en),
    .mem_we (mem_we),
    .mem_be (mem_be),
    .done   (done),
    .err    (err),
    .busy   (busy)
);

// File: tb/test_lsu_core.sv
module test_lsu_core;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int NB = DW / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [1:0]      req_size = '0;
    logic [DW-1:0]   req_data = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [AW-1:0]   mem_addr;
    logic            mem_en;
    logic            mem_we;
    logic [NB-1:0]   mem_be;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata;
    logic            busy;
    logic            done;
    logic            err;
    logic [DW-1:0]   result;
    logic [AW-1:0]   addr_next;

    int total = 0;
    int failed = 0;
    int en_total = 0;
    logic [NB-1:0] last_be = '0;

    logic [7:0] mem     [0:255];
    logic [7:0] exp_mem [0:255];

    lsu_core #(.DW(DW), .AW(AW)) i_lsu_core (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_size(req_size), .req_data(req_data), .req_addr(req_addr),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .err(err), .result(result), .addr_next(addr_next)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] seed_byte(int i);
        return 8'((i * 37 + 11) ^ (i >> 3) ^ ((i & 1) ? 8'h80 : 8'h00));
    endfunction

    // memory model: synchronous, byte lanes little-endian
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= seed_byte(i);
            mem_rdata <= '0;
        end else if (mem_en) begin
            en_total <= en_total + 1;
            last_be  <= mem_be;
            for (int l = 0; l < NB; l++) begin
                if (mem_we && mem_be[l])
                    mem[(int'(mem_addr[7:0]) & ~(NB-1)) + l] <= mem_wdata[8*l +: 8];
                mem_rdata[8*l +: 8] <= mem[(int'(mem_addr[7:0]) & ~(NB-1)) + l];
            end
        end
    end

    function automatic logic [DW-1:0] exp_load(int a, int nbytes, bit sgn);
        logic [63:0] v;
        v = '0;
        for (int k = 0; k < nbytes; k++) v[8*k +: 8] = exp_mem[(a + k) & 255];
        if (sgn && v[8*nbytes-1])
            for (int i = 8*nbytes; i < 64; i++) v[i] = 1'b1;
        return v[DW-1:0];
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic check_word(int a, string req);
        int base;
        base = a & 255 & ~(NB-1);
        for (int l = 0; l < NB; l++)
            check(mem[base+l] == exp_mem[base+l], req, 64'(mem[base+l]), 64'(exp_mem[base+l]));
    endtask

    // issues one request; returns latency in cycles and memory enables seen
    task automatic run_op(input logic [2:0] op, input logic [1:0] sz,
                          input logic [DW-1:0] d, input logic [AW-1:0] a,
                          output int lat, output int ens);
        int en0;
        @(negedge clk);
        en0 = en_total;
        req_valid = 1'b1; req_op = op; req_size = sz; req_data = d; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        ens = en_total - en0;
    endtask

    initial begin
        int lat, ens, a, nb;
        logic [DW-1:0] d, e;
        logic [2:0] op;
        logic [1:0] sz;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) exp_mem[i] = seed_byte(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err && !mem_en && !mem_we, "R1", 64'({busy,done,err,mem_en,mem_we}), 64'd0);
        check(result == '0 && addr_next == '0, "R1", 64'(result), 64'd0);
        rst_n = 1'b1;

        // R5/R3/R4 directed sign corners: byte 0x80 at offset 1
        run_op(3'd2, 2'd0, 32'h1234_5680, 16'h0011, lat, ens);
        for (int k = 0; k < 1; k++) exp_mem[8'h11 + k] = 8'h80;
        check(last_be == 4'b0010, "R5", 64'(last_be), 64'h2);
        check(lat == 2, "R10", 64'(lat), 64'd2);
        check_word(16'h0011, "R6");
        run_op(3'd0, 2'd0, '0, 16'h0011, lat, ens);
        check(result == 32'hFFFF_FF80, "R3", 64'(result), 64'hFFFF_FF80);
        check(lat == 3, "R10", 64'(lat), 64'd3);
        run_op(3'd1, 2'd0, '0, 16'h0011, lat, ens);
        check(result == 32'h0000_0080, "R4", 64'(result), 64'h80);
        // halfword 0x8001 at offset 2
        run_op(3'd2, 2'd1, 32'hAAAA_8001, 16'h0022, lat, ens);
        exp_mem[8'h22] = 8'h01; exp_mem[8'h23] = 8'h80;
        check(last_be == 4'b1100, "R5", 64'(last_be), 64'hC);
        check_word(16'h0022, "R6");
        run_op(3'd0, 2'd1, '0, 16'h0022, lat, ens);
        check(result == 32'hFFFF_8001, "R3", 64'(result), 64'hFFFF_8001);
        run_op(3'd1, 2'd1, '0, 16'h0022, lat, ens);
        check(result == 32'h0000_8001, "R4", 64'(result), 64'h8001);

        // R2 illegal size on load and store, illegal opcode
        run_op(3'd0, 2'd3, '0, 16'h0040, lat, ens);
        check(err && lat == 1 && ens == 0, "R2", 64'({err, 8'(lat), 8'(ens)}), 64'h1_01_00);
        run_op(3'd2, 2'd3, 32'hDEAD_BEEF, 16'h0040, lat, ens);
        check(err && lat == 1 && ens == 0, "R2", 64'({err, 8'(lat), 8'(ens)}), 64'h1_01_00);
        check_word(16'h0040, "R2");
        run_op(3'd7, 2'd0, 32'h1, 16'h0044, lat, ens);
        check(err && ens == 0, "R2", 64'({err, 8'(ens)}), 64'h1_00);

        // R8 pop at address zero wraps
        run_op(3'd4, 2'd0, '0, 16'h0000, lat, ens);
        check(addr_next == 16'hFFFC, "R8", 64'(addr_next), 64'hFFFC);
        check(result == exp_load(0, NB, 1'b0), "R8", 64'(result), 64'(exp_load(0, NB, 1'b0)));

        // R11 request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_size = 2'd2; req_addr = 16'h0050; req_data = '0;
        @(negedge clk);
        req_op = 3'd5; req_data = 32'hCAFE_F00D;
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        check(result == exp_load(16'h50, 4, 1'b0), "R11", 64'(result), 64'(exp_load(16'h50, 4, 1'b0)));
        repeat (3) begin
            @(negedge clk);
            check(!done && !busy, "R11", 64'({done, busy}), 64'd0);
        end

        // random mix
        for (int n = 0; n < 400; n++) begin
            op = 3'($urandom % 6);
            sz = 2'($urandom % 3);
            d  = $urandom;
            nb = 1 << sz;
            if (op == 3'd3 || op == 3'd4) begin
                sz = 2'($urandom % 4);
                nb = NB;
            end
            a = int'($urandom % 256) & ~(nb - 1);
            run_op(op, sz, d, 16'(a), lat, ens);
            case (op)
                3'd0, 3'd1: begin
                    e = exp_load(a, nb, op == 3'd0);
                    check(result == e, op == 3'd0 ? "R3" : "R4", 64'(result), 64'(e));
                    check(lat == 3 && !err && addr_next == 16'(a), "R10", 64'(lat), 64'd3);
                end
                3'd2: begin
                    for (int k = 0; k < nb; k++) exp_mem[a + k] = d[8*k +: 8];
                    check_word(a, "R6");
                    check(lat == 2, "R10", 64'(lat), 64'd2);
                end
                3'd3: begin
                    for (int k = 0; k < NB; k++) exp_mem[a + k] = d[8*k +: 8];
                    check_word(a, "R7");
                    check(addr_next == 16'(a + NB), "R7", 64'(addr_next), 64'(a + NB));
                end
                3'd4: begin
                    e = exp_load(a, NB, 1'b0);
                    check(result == e, "R8", 64'(result), 64'(e));
                    check(addr_next == 16'(a - NB), "R8", 64'(addr_next), 64'(16'(a - NB)));
                end
                default: begin
                    check(result == d && ens == 0 && lat == 1, "R9", 64'(result), 64'(d));
                    check(addr_next == 16'(a), "R9", 64'(addr_next), 64'(a));
                end
            endcase
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule